// File: doc/BRIEF.md
# Sync Mode-Change Detector

This block watches a display's horizontal and vertical sync inputs and raises a sticky flag when the incoming video mode appears to have changed. Three detectors can set the flag. The first measures each horizontal period in clock cycles and compares it with the previous period against a 4-bit threshold. The second tracks the polarity of each sync signal. The third reports a period counter that runs past its limit, which means sync has stopped or slowed too much. Each detector has its own disable bit, and all three are disabled after reset.

The horizontal period is the number of clock cycles from one rising edge of hsync to the next. The vertical period is the number of hsync rising edges from one rising edge of vsync to the next. A signal's polarity is taken once per period from where it spends most of that period. Firmware reads the flag through a small two-register interface and clears it by writing 1. When the interrupt enable bit is set, a set flag drives a non-maskable interrupt request.

Top module: `sync_mode_watch`

## Requirements
- R1: After reset the control register at address 0 reads 0xF7: all three detectors are disabled, the interrupt is disabled and the threshold is 15. The flag and the interrupt request are 0.
- R2: The control register layout is: bit0 disables the period-difference check, bit1 disables the polarity check, bit2 disables the overflow check, bit3 enables the interrupt, and bits 7:4 hold the threshold. A written value reads back unchanged at address 0. Address 1 reads the flag in bit0 and zeros in the other bits.
- R3: With the difference check on, the flag is set when the absolute difference between two successive horizontal periods is strictly greater than the threshold. A difference equal to the threshold does not set it. This holds whether the period grows or shrinks.
- R4: The first horizontal period measured after the difference check is enabled only stores a new reference. Periods seen while the check was off never take part in a comparison.
- R5: With the polarity check on, the flag is set when the horizontal polarity changes between two successive periods. The horizontal polarity is 1 when hsync was high on more than half of the period's clock cycles.
- R6: With the polarity check on, the flag is set when the vertical polarity changes between two successive frames. The vertical polarity is 1 when vsync was high at more than half of the frame's hsync rising edges.
- R7: With the overflow check on, the flag is set when more than 2^H_W-1 clock cycles pass without an hsync rising edge. A period of exactly 2^H_W-1 cycles does not set it.
- R8: With the overflow check on, the flag is set when more than 2^V_W-1 hsync rising edges pass without a vsync rising edge. A frame of exactly 2^V_W-1 lines does not set it.
- R9: A detector whose disable bit is 1 never sets the flag, whatever the sync inputs do.
- R10: The flag is sticky. Writing 1 to bit0 at address 1 clears it, and writing 0 there leaves it unchanged.
- R11: When a detection and a clear write fall in the same cycle, the flag ends up set.
- R12: The interrupt request is 1 exactly when the flag is set and the interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, already synchronous to clk |
| vsync | input | 1 | Vertical sync, already synchronous to clk |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| mute_flag | output | 1 | Sticky mode-change flag |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
A corrupt stored reference period or polarity shows up as a spurious or missing flag at the very next rising edge of the same sync signal. For horizontal faults that is one line later. For vertical faults it can be a whole frame later. A wrong saturation or one-shot state in a period counter shows up only on a period that reaches the counter limit, so the bench drives periods of exactly the limit and one beyond it. Flag priority faults appear in the cycle after a clear write that coincides with a sync edge. The bench places a clear write on that exact cycle.

// File: rtl/smw_pkg.sv
package smw_pkg;

  localparam int  THR_W     = 4;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Control register; field order fixes the bit positions seen by software.
  typedef struct packed {
    logic [THR_W-1:0] thr;       // bits 7:4
    logic             irq_en;    // bit 3
    logic             ovf_off;   // bit 2
    logic             pol_off;   // bit 1
    logic             diff_off;  // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{thr: 4'hF, irq_en: 1'b0, ovf_off: 1'b1,
                                 pol_off: 1'b1, diff_off: 1'b1};

  // Distance between two period counts (widths up to 16 bits).
  function automatic logic [15:0] abs_gap(input logic [15:0] a, input logic [15:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // True when the high samples make up more than half of the total.
  function automatic logic mostly_high(input logic [15:0] hi, input logic [15:0] tot);
    return {hi, 1'b0} > {1'b0, tot};
  endfunction

endpackage

// File: rtl/smw_period_meter.sv
module smw_period_meter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,    // sync level being measured
  input  logic          tick,   // unit of counting
  output logic          rise,   // period boundary, result valid this cycle
  output logic [CW-1:0] cnt,    // ticks in the period that ends here
  output logic          pol,    // majority level over that period
  output logic          ovf     // one pulse when the period exceeds the counter
);
  import smw_pkg::*;

  localparam logic [CW-1:0] CMAX = '1;

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] hi_q;
  logic          sat_q;

  assign rise = lvl & ~lvl_q;
  assign cnt  = cnt_q;
  assign pol  = mostly_high(16'(hi_q), 16'(cnt_q));
  assign ovf  = tick & ~rise & (cnt_q == CMAX) & ~sat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      hi_q  <= '0;
      sat_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (rise) begin
        cnt_q <= CW'(tick);
        hi_q  <= CW'(tick & lvl);
        sat_q <= 1'b0;
      end else if (tick) begin
        if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        else               sat_q <= 1'b1;
        if (lvl && hi_q != CMAX) hi_q <= hi_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/smw_hdiff_cmp.sv
module smw_hdiff_cmp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    thr,
  input  logic          meas_vld,
  input  logic [CW-1:0] meas_cnt,
  output logic          hit
);
  import smw_pkg::*;

  logic [CW-1:0] prev_q;
  logic          primed_q;
  logic [15:0]   gap;

  assign gap = abs_gap(16'(meas_cnt), 16'(prev_q));
  assign hit = en & meas_vld & primed_q & (gap > 16'(thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (!en) begin
      primed_q <= 1'b0;
    end else if (meas_vld) begin
      prev_q   <= meas_cnt;
      primed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/smw_pol_track.sv
module smw_pol_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic meas_vld,
  input  logic meas_pol,
  output logic hit
);
  logic prev_q;
  logic primed_q;

  assign hit = en & meas_vld & primed_q & (meas_pol != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (!en) begin
      primed_q <= 1'b0;
    end else if (meas_vld) begin
      prev_q   <= meas_pol;
      primed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/smw_regs.sv
module smw_regs (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 addr,
  input  logic [7:0]           wdata,
  input  logic                 set_evt,
  output smw_pkg::ctrl_t       ctrl,
  output logic                 flag,
  output logic                 clr_req,
  output logic [7:0]           rdata
);
  import smw_pkg::*;

  assign clr_req = wr & (addr == ADDR_STAT) & wdata[0];
  assign rdata   = (addr == ADDR_CTRL) ? ctrl : {7'b0, flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
    end else if (wr && addr == ADDR_CTRL) begin
      ctrl <= ctrl_t'(wdata);
    end
  end

  // Set has priority over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

endmodule

// File: rtl/sync_mode_watch.sv
module sync_mode_watch #(
  parameter int H_W = 8,   // clock cycles per line counter width
  parameter int V_W = 6    // lines per frame counter width
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mute_flag,
  output logic       nmi_req
);
  import smw_pkg::*;

  localparam int N_CH = 2;   // 0: horizontal, 1: vertical

  ctrl_t            ctrl;
  logic             h_rise, v_rise;
  logic [H_W-1:0]   h_cnt;
  logic [V_W-1:0]   v_cnt;
  logic             h_pol, v_pol;
  logic             h_ovf, v_ovf;
  logic             diff_hit;
  logic [N_CH-1:0]  ch_rise, ch_pol, pol_hit;
  logic             ovf_hit;
  logic             set_evt;
  logic             clr_req;

  smw_period_meter #(.CW(H_W)) u_hmeter (
    .clk(clk), .rst_n(rst_n), .lvl(hsync), .tick(1'b1),
    .rise(h_rise), .cnt(h_cnt), .pol(h_pol), .ovf(h_ovf)
  );

  smw_period_meter #(.CW(V_W)) u_vmeter (
    .clk(clk), .rst_n(rst_n), .lvl(vsync), .tick(h_rise),
    .rise(v_rise), .cnt(v_cnt), .pol(v_pol), .ovf(v_ovf)
  );

  smw_hdiff_cmp #(.CW(H_W)) u_hdiff (
    .clk(clk), .rst_n(rst_n), .en(~ctrl.diff_off), .thr(ctrl.thr),
    .meas_vld(h_rise), .meas_cnt(h_cnt), .hit(diff_hit)
  );

  assign ch_rise = {v_rise, h_rise};
  assign ch_pol  = {v_pol, h_pol};

  for (genvar g = 0; g < N_CH; g++) begin : g_pol
    smw_pol_track u_pol (
      .clk(clk), .rst_n(rst_n), .en(~ctrl.pol_off),
      .meas_vld(ch_rise[g]), .meas_pol(ch_pol[g]), .hit(pol_hit[g])
    );
  end

  assign ovf_hit = ~ctrl.ovf_off & (h_ovf | v_ovf);
  assign set_evt = diff_hit | (|pol_hit) | ovf_hit;

  smw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set_evt(set_evt), .ctrl(ctrl), .flag(mute_flag), .clr_req(clr_req),
    .rdata(reg_rdata)
  );

  assign nmi_req = mute_flag & ctrl.irq_en;

endmodule

// File: rtl/sync_mode_watch_chk.sv
module sync_mode_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_bits,
  input logic       mute_flag,
  input logic       nmi_req,
  input logic       set_evt,
  input logic       clr_req,
  input logic       h_ovf,
  input logic       v_ovf
);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_flag && !clr_req) |=> mute_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !mute_flag);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> mute_flag);

  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_flag) |-> $past(set_evt));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&ctrl_bits[2:0]) |=> !$rose(mute_flag));

  p_nmi_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[3] |-> !nmi_req);

  p_nmi_raise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_bits[3] && mute_flag) |-> nmi_req);

  p_hovf_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    h_ovf |=> !h_ovf);

  p_vovf_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    v_ovf |=> !v_ovf);

endmodule

bind sync_mode_watch sync_mode_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_bits(ctrl), .mute_flag(mute_flag),
  .nmi_req(nmi_req), .set_evt(set_evt), .clr_req(clr_req),
  .h_ovf(h_ovf), .v_ovf(v_ovf)
);

// File: tb/sync_mode_watch_bench.sv
module sync_mode_watch_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b0, vs = 1'b0;
  logic       reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       mute_flag, nmi_req;

  always #2 clk = ~clk;   // 250 MHz

  sync_mode_watch u_sync_mode_watch (
    .clk(clk), .rst_n(rst_n), .hsync(hs), .vsync(vs),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mute_flag(mute_flag), .nmi_req(nmi_req)
  );

  typedef struct {
    string      tag;
    logic [9:0] exp;    // {nmi, flag, rdata}
    logic [9:0] mask;
    time        stamp;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  logic       rd_addr = 1'b0;
  bit         pend = 1'b0;
  logic       pend_addr = 1'b0;
  logic [7:0] pend_data = 8'h00;
  int         pend_cyc = 0;

  // Monitor: compare items pushed before the current falling edge.
  always @(negedge clk) begin
    item_t      it;
    logic [9:0] obs;
    while (sb_q.size() > 0 && sb_q[0].stamp < $time) begin
      it  = sb_q.pop_front();
      obs = {nmi_req, mute_flag, reg_rdata};
      n_cmp++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b (mask %b)", it.tag, obs, it.exp, it.mask);
      end
    end
  end

  task automatic push(string tag, logic [9:0] exp, logic [9:0] mask);
    item_t it;
    it.tag = tag; it.exp = exp; it.mask = mask; it.stamp = $time;
    sb_q.push_back(it);
  endtask

  task automatic exp_flag(string tag, bit f);
    push(tag, {1'b0, f, 8'h00}, 10'b01_0000_0000);
  endtask

  task automatic exp_irq(string tag, bit n, bit f);
    push(tag, {n, f, 8'h00}, 10'b11_0000_0000);
  endtask

  task automatic exp_reg(string tag, logic [7:0] v);
    push(tag, {2'b00, v}, 10'b00_1111_1111);
  endtask

  // Schedule a one-cycle register write inside the next line.
  task automatic post_wr(logic a, logic [7:0] d, int cyc);
    pend = 1'b1; pend_addr = a; pend_data = d; pend_cyc = cyc;
  endtask

  // One line: rising hsync at cycle 0, low for the last 'low' cycles.
  task automatic line(int per, int low, bit vlev);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      hs = (i < per - low);
      vs = vlev;
      if (pend && i == pend_cyc) begin
        reg_wr = 1'b1; reg_addr = pend_addr; reg_wdata = pend_data; pend = 1'b0;
      end else begin
        reg_wr = 1'b0; reg_addr = rd_addr;
      end
    end
  endtask

  // Frame of n lines with vsync high on the first vhi lines.
  task automatic frame(int n, int per, int low, int vhi);
    for (int l = 0; l < n; l++) line(per, low, l < vhi);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    push("R1 reset state", {2'b00, 8'hF7}, 10'b11_1111_1111);
    repeat (2) @(negedge clk);
    rd_addr = 1'b1;

    // R9: every detector off, all three kinds of change applied
    frame(2, 40, 4, 2);
    frame(2, 90, 4, 2);
    frame(2, 40, 36, 2);
    frame(10, 40, 4, 8);
    frame(70, 40, 4, 0);
    line(300, 4, 1'b0);
    exp_flag("R9 disabled detectors leave flag clear", 1'b0);

    // R2 / R3: difference check with threshold 15
    post_wr(1'b0, 8'hF6, 1);
    frame(2, 40, 4, 2);
    frame(3, 40, 4, 2);
    rd_addr = 1'b0;
    line(40, 4, 1'b0);
    exp_reg("R2 control readback", 8'hF6);
    line(40, 4, 1'b0);
    rd_addr = 1'b1;
    frame(2, 55, 4, 2);
    exp_flag("R3 difference equal to threshold", 1'b0);
    frame(2, 71, 4, 2);
    exp_irq("R3 difference above threshold, R12 masked", 1'b0, 1'b1);

    // R10: sticky flag, write-1-to-clear
    post_wr(1'b1, 8'h00, 5);
    frame(2, 71, 4, 2);
    exp_flag("R10 writing 0 keeps flag", 1'b1);
    post_wr(1'b1, 8'h01, 5);
    frame(2, 71, 4, 2);
    exp_flag("R10 writing 1 clears flag", 1'b0);
    frame(2, 60, 4, 2);
    exp_flag("R3 shrink of 11 under threshold 15", 1'b0);
    post_wr(1'b0, 8'h36, 1);
    frame(2, 60, 4, 2);
    frame(2, 64, 4, 2);
    exp_flag("R3 growth of 4 over threshold 3", 1'b1);
    post_wr(1'b1, 8'h01, 5);
    frame(2, 60, 4, 2);
    exp_flag("R3 shrink of 4 over threshold 3", 1'b1);

    // R4: re-enabling primes instead of comparing with a stale period
    post_wr(1'b0, 8'h37, 1);
    frame(2, 60, 4, 2);
    post_wr(1'b1, 8'h01, 5);
    frame(2, 90, 4, 2);
    post_wr(1'b0, 8'h36, 1);
    frame(3, 90, 4, 2);
    exp_flag("R4 first period after enable only primes", 1'b0);

    // R5: horizontal polarity
    post_wr(1'b0, 8'hF5, 1);
    frame(10, 40, 4, 2);
    frame(10, 40, 4, 2);
    exp_flag("R5 steady polarity", 1'b0);
    frame(10, 40, 36, 2);
    exp_flag("R5 horizontal polarity flip", 1'b1);

    // R6: vertical polarity
    post_wr(1'b1, 8'h01, 5);
    frame(10, 40, 36, 2);
    frame(10, 40, 36, 2);
    exp_flag("R6 steady vertical polarity", 1'b0);
    frame(10, 40, 36, 8);
    frame(1, 40, 36, 8);
    exp_flag("R6 vertical polarity flip", 1'b1);

    // R7: horizontal overflow at 255 cycles
    post_wr(1'b0, 8'hF3, 1);
    frame(10, 40, 36, 8);
    post_wr(1'b1, 8'h01, 5);
    frame(10, 40, 4, 2);
    exp_flag("R7 overflow check quiet on normal lines", 1'b0);
    line(255, 4, 1'b0);
    line(40, 4, 1'b0);
    exp_flag("R7 period of exactly the limit", 1'b0);
    line(256, 4, 1'b0);
    line(40, 4, 1'b0);
    exp_flag("R7 period one beyond the limit", 1'b1);

    // R8: vertical overflow at 63 lines
    post_wr(1'b1, 8'h01, 5);
    frame(63, 40, 4, 1);
    frame(1, 40, 4, 1);
    exp_flag("R8 frame of exactly the limit", 1'b0);
    frame(64, 40, 4, 1);
    frame(1, 40, 4, 1);
    exp_flag("R8 frame one beyond the limit", 1'b1);

    // R12: interrupt request follows flag and enable
    post_wr(1'b0, 8'hFB, 1);
    frame(2, 40, 4, 1);
    exp_irq("R12 request with flag and enable", 1'b1, 1'b1);
    post_wr(1'b1, 8'h01, 5);
    frame(2, 40, 4, 1);
    exp_irq("R12 request drops with flag", 1'b0, 1'b0);

    // R11: detection and clear in the same cycle
    post_wr(1'b0, 8'h36, 1);
    frame(3, 40, 4, 1);
    post_wr(1'b1, 8'h01, 5);
    frame(1, 40, 4, 1);
    exp_flag("R11 flag clear before collision", 1'b0);
    frame(1, 60, 4, 1);
    post_wr(1'b1, 8'h01, 0);
    frame(1, 40, 4, 1);
    exp_flag("R11 detection beats clear", 1'b1);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule